// File: doc/BRIEF.md
# Octal ALU Instruction Decoder

This block turns one 8-bit instruction byte, together with the current carry flag, into the control set that drives an arithmetic/logic unit. The work is all combinational. An ALU instruction has the two top bits set to `10`. Bits 5:3 choose one of eight operations. Bits 2:0 name the source register, where value 7 stands for memory. The decoder reads only the class bits and the operation field. Register selection is handled elsewhere and has no effect on any output here.

The three mode lines are active low. They come from partial pattern matches on the operation field, in the way a product-term array works, and one line is shared by all three logic operations. The same field also produces four other outputs:
- an invert request for the second operand,
- the carry entering the adder,
- a result write enable,
- a flag update enable.

Compare is a subtraction whose result is thrown away, so it updates the flags and does not write. For any opcode outside the ALU class, every output sits in its idle state.

The ports are plain control pins, so there is no valid/ready handshake and no back-pressure. Outputs follow the inputs in the same cycle.

Top module: `alu_op_decoder`

## Requirements
- R1: When `opcode[7:6]` is not `10`, all three mode lines are 1 and `op_b_invert`, `adder_cin`, `result_we` and `flags_we` are all 0.
- R2: With `opcode[7:6]=10`, `mode1_n` is 0 only for field `opcode[5:3]=100` (AND).
- R3: With `opcode[7:6]=10`, `mode2_n` is 0 only for field `110` (OR).
- R4: With `opcode[7:6]=10`, `mode3_n` is 0 exactly for fields `100`, `101` and `110` (AND, XOR, OR). It stays 1 for fields `000`, `001`, `010`, `011` and `111`.
- R5: With `opcode[7:6]=10`, `op_b_invert` is 1 exactly for fields `010` (subtract), `011` (subtract with borrow) and `111` (compare).
- R6: With `opcode[7:6]=10`, `adder_cin` is 0 for fields `000` (add), `100`, `101` and `110`, whatever the carry flag is.
- R7: For field `001` (add with carry), `adder_cin` equals `carry_flag`.
- R8: For field `011`, `adder_cin` equals the inverse of `carry_flag`. For fields `010` and `111` it is 1.
- R9: With `opcode[7:6]=10`, `result_we` is 1 for every field except `111` (compare), where it is 0.
- R10: `flags_we` is 1 for every opcode with `opcode[7:6]=10`.
- R11: `opcode[2:0]` (register selector, 7 = memory) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Instruction byte: class in 7:6, operation in 5:3, register in 2:0 |
| carry_flag | input | 1 | Current carry flag |
| mode1_n | output | 1 | Active-low mode line, low for AND |
| mode2_n | output | 1 | Active-low mode line, low for OR |
| mode3_n | output | 1 | Active-low mode line, low for all logic operations |
| op_b_invert | output | 1 | Invert second operand before the adder |
| adder_cin | output | 1 | Carry into the adder |
| result_we | output | 1 | Write the ALU result back |
| flags_we | output | 1 | Update the status flags |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle the opcode is applied. A wrong product term shows up as one operation, or one class of opcodes, that selects the wrong function. A broken carry path shows up only for the carry-dependent operations, and only under one flag value. For that reason the whole opcode space is swept under both flag values. A leak in the class gate appears on non-ALU opcodes as a mode line that drops low or an enable that rises.

// File: rtl/alu_op_decoder_pkg.sv
package alu_op_decoder_pkg;
  localparam int OPC_W   = 8;
  localparam int FLD_W   = 3;
  localparam int NUM_OPS = 1 << FLD_W;
  localparam int CLS_W   = OPC_W - 2 * FLD_W;
  localparam logic [CLS_W-1:0] CLS_ALU = 2'b10;

  typedef enum logic [FLD_W-1:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CMP = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_dec_pterm.sv
module alu_dec_pterm #(
  parameter int W = 3,
  parameter logic [W-1:0] CARE  = '1,
  parameter logic [W-1:0] MATCH = '0
) (
  input  logic [W-1:0] in_bits,
  output logic         hit
);
  // product term: every cared bit must agree with MATCH
  assign hit = ~|((in_bits ^ MATCH) & CARE);
endmodule

// File: rtl/alu_dec_mode.sv
module alu_dec_mode
  import alu_op_decoder_pkg::*;
(
  input  logic [FLD_W-1:0] field,
  output logic             m1_n,
  output logic             m2_n,
  output logic             m3_n
);
  logic t_and, t_or, t_m3a, t_m3b;

  alu_dec_pterm #(.W(FLD_W), .CARE(3'b111), .MATCH(3'b100)) u_and (.in_bits(field), .hit(t_and));
  alu_dec_pterm #(.W(FLD_W), .CARE(3'b111), .MATCH(3'b110)) u_or  (.in_bits(field), .hit(t_or));
  alu_dec_pterm #(.W(FLD_W), .CARE(3'b110), .MATCH(3'b100)) u_m3a (.in_bits(field), .hit(t_m3a));
  alu_dec_pterm #(.W(FLD_W), .CARE(3'b101), .MATCH(3'b100)) u_m3b (.in_bits(field), .hit(t_m3b));

  assign m1_n = ~t_and;
  assign m2_n = ~t_or;
  assign m3_n = ~(t_m3a | t_m3b);

  always_comb begin
    if (!$isunknown(field)) begin
      assert_and_in_logic_R2: assert (m1_n || !m3_n);
      assert_or_in_logic_R3:  assert (m2_n || !m3_n);
      assert_one_sel_R4:      assert ($onehot0({~m1_n, ~m2_n}));
    end
  end
endmodule

// File: rtl/alu_dec_ctrl.sv
module alu_dec_ctrl
  import alu_op_decoder_pkg::*;
(
  input  logic [FLD_W-1:0] field,
  input  logic             cflag,
  output logic             invert,
  output logic             cin,
  output logic             keep_result
);
  logic [NUM_OPS-1:0] op_hit;
  logic               t_sub_pair;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    alu_dec_pterm #(.W(FLD_W), .CARE('1), .MATCH(FLD_W'(k)))
      u_row (.in_bits(field), .hit(op_hit[k]));
  end

  alu_dec_pterm #(.W(FLD_W), .CARE(3'b110), .MATCH(3'b010))
    u_subpair (.in_bits(field), .hit(t_sub_pair));

  assign invert      = t_sub_pair | op_hit[OP_CMP];
  assign cin         = (op_hit[OP_ADC] & cflag) | (op_hit[OP_SBB] & ~cflag)
                     | op_hit[OP_SUB] | op_hit[OP_CMP];
  assign keep_result = ~op_hit[OP_CMP];

  always_comb begin
    if (!$isunknown({field, cflag})) begin
      assert_single_op_R5:  assert ($onehot(op_hit));
      assert_cmp_nowr_R9:   assert (keep_result || invert);
      assert_cin_needs_R6:  assert (!cin || invert || op_hit[OP_ADC]);
    end
  end
endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_op_decoder_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             carry_flag,
  output logic             mode1_n,
  output logic             mode2_n,
  output logic             mode3_n,
  output logic             op_b_invert,
  output logic             adder_cin,
  output logic             result_we,
  output logic             flags_we
);
  logic [FLD_W-1:0] field;
  logic             is_alu;
  logic             raw_m1_n, raw_m2_n, raw_m3_n;
  logic             raw_inv, raw_cin, raw_keep;
  logic             reg_sel_unused;

  assign field          = opcode[2*FLD_W-1:FLD_W];
  assign reg_sel_unused = ^opcode[FLD_W-1:0];

  alu_dec_pterm #(.W(CLS_W), .CARE('1), .MATCH(CLS_ALU))
    u_class (.in_bits(opcode[OPC_W-1:2*FLD_W]), .hit(is_alu));

  alu_dec_mode u_mode (
    .field(field), .m1_n(raw_m1_n), .m2_n(raw_m2_n), .m3_n(raw_m3_n)
  );

  alu_dec_ctrl u_ctrl (
    .field(field), .cflag(carry_flag),
    .invert(raw_inv), .cin(raw_cin), .keep_result(raw_keep)
  );

  assign mode1_n     = raw_m1_n | ~is_alu;
  assign mode2_n     = raw_m2_n | ~is_alu;
  assign mode3_n     = raw_m3_n | ~is_alu;
  assign op_b_invert = raw_inv  & is_alu;
  assign adder_cin   = raw_cin  & is_alu;
  assign result_we   = raw_keep & is_alu;
  assign flags_we    = is_alu;

  always_comb begin
    if (!$isunknown({opcode, carry_flag})) begin
      assert_idle_R1:     assert (flags_we || (mode1_n && mode2_n && mode3_n
                                  && !op_b_invert && !adder_cin && !result_we));
      assert_we_flag_R10: assert (!result_we || flags_we);
      assert_logic_R4:    assert (mode3_n || (!op_b_invert && !adder_cin));
    end
  end
endmodule

// File: tb/alu_op_decoder_bench.sv
module alu_op_decoder_bench;
  typedef struct packed {
    logic [7:0] opc;
    logic       cf;
    logic [6:0] outs; // m1 m2 m3 inv cin we fwe
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic carry_flag = 1'b0;
  logic mode1_n, mode2_n, mode3_n, op_b_invert, adder_cin, result_we, flags_we;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  alu_op_decoder u_alu_op_decoder (
    .opcode(opcode), .carry_flag(carry_flag),
    .mode1_n(mode1_n), .mode2_n(mode2_n), .mode3_n(mode3_n),
    .op_b_invert(op_b_invert), .adder_cin(adder_cin),
    .result_we(result_we), .flags_we(flags_we)
  );

  function automatic logic [6:0] model(input logic [7:0] o, input logic cf);
    logic m1, m2, m3, inv, cin, we, fwe;
    m1 = 1; m2 = 1; m3 = 1; inv = 0; cin = 0; we = 0; fwe = 0;
    if (o[7:6] == 2'b10) begin
      fwe = 1; we = 1;
      case (o[5:3])
        3'd0: cin = 0;
        3'd1: cin = cf;
        3'd2: begin inv = 1; cin = 1; end
        3'd3: begin inv = 1; cin = ~cf; end
        3'd4: begin m1 = 0; m3 = 0; end
        3'd5: m3 = 0;
        3'd6: begin m2 = 0; m3 = 0; end
        default: begin inv = 1; cin = 1; we = 0; end
      endcase
    end
    return {m1, m2, m3, inv, cin, we, fwe};
  endfunction

  task automatic chk(input string req, input string name, input logic act, input logic exp,
                     input logic [7:0] o, input logic cf);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s opcode=%o cf=%b actual=%b expected=%b", req, name, o, cf, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o, input logic cf);
    item_t it;
    @(posedge clk);
    opcode <= o;
    carry_flag <= cf;
    it.opc = o; it.cf = cf; it.outs = model(o, cf);
    sb_q.push_back(it);
  endtask

  // monitor: compares half a cycle after each drive
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      string cls;
      it = sb_q.pop_front();
      cls = (it.opc[7:6] == 2'b10) ? "" : "R1/";
      // R11: model ignores bits 2:0, so any register value must match
      chk({cls, "R2/R11"}, "mode1_n", mode1_n, it.outs[6], it.opc, it.cf);
      chk({cls, "R3"}, "mode2_n", mode2_n, it.outs[5], it.opc, it.cf);
      chk({cls, "R4"}, "mode3_n", mode3_n, it.outs[4], it.opc, it.cf);
      chk({cls, "R5"}, "op_b_invert", op_b_invert, it.outs[3], it.opc, it.cf);
      chk({cls, "R6/R7/R8"}, "adder_cin", adder_cin, it.outs[2], it.opc, it.cf);
      chk({cls, "R9"}, "result_we", result_we, it.outs[1], it.opc, it.cf);
      chk({cls, "R10"}, "flags_we", flags_we, it.outs[0], it.opc, it.cf);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: idle opcode 000 gives inactive outputs (R1)
    chk("R1", "reset_mode", mode1_n & mode2_n & mode3_n, 1'b1, opcode, carry_flag);
    chk("R1", "reset_en", op_b_invert | adder_cin | result_we | flags_we, 1'b0, opcode, carry_flag);
    rst_n = 1'b1;
    // directed corners: memory operand compare, borrow under both flags
    drive(8'o277, 1'b0);
    drive(8'o237, 1'b1);
    drive(8'o230, 1'b0);
    drive(8'o217, 1'b1);
    drive(8'o010, 1'b1);
    // full sweep of every opcode under both carry flag values
    for (int f = 0; f < 2; f++)
      for (int o = 0; o < 256; o++)
        drive(8'(o), f[0]);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule